// File: doc/BRIEF.md
# Timestamped Event Cluster Packer

The block receives one 16-bit sample word per event tick. The word holds four logic channels, and each channel is sampled at four sub-phases within the tick. The block regroups those bits so that each channel's four sub-samples sit next to each other. It then collects seven consecutive ticks into a cluster. The cluster leads with the tick index of its first event. Complete clusters leave as a byte stream under a valid/ready handshake. A chunk marker flags the final byte of every group of `CHUNK_CLUSTERS` clusters.

Ticks that only repeat the previous sample are not stored. A reader rebuilds them from the jump between cluster timestamps: every tick that is missing took the last sub-sample of the previous cluster. To keep that jump unambiguous after the timestamp wraps, a cluster is forced after at most `FORCE_TICKS` ticks. If a cluster completes while the output still holds an earlier one, the new cluster is dropped and a sticky flag records the loss.

Top module: `evt_cluster_packer`

## Requirements
- R1: After reset `out_valid` and `overflow` are 0, the tick counter is 0 and the last stored sample is taken as all channels low.
- R2: In the input word, bit 4*k+c is channel c at sub-sample k. In each stored event word, bit 4*c+k is channel c at sub-sample k, for c and k in 0..3.
- R3: A cluster is 16 bytes: the timestamp low byte, the timestamp high byte, then seven event words in tick order, each sent low byte first. The timestamp is the tick index of the cluster's first event. The tick counter advances by one on every `smp_valid` and wraps modulo 2^`TS_W`.
- R4: When no cluster is open, a tick opens one if its word differs from the last stored sub-sample copied to all four sub-phases. A tick equal to that word is discarded. An open cluster takes the next seven ticks whatever their value.
- R5: When no cluster is open, a tick whose index is `FORCE_TICKS` or more past the previous cluster's timestamp opens a cluster even if it is idle. Before the first cluster, the previous timestamp is taken as 0.
- R6: `out_last` is 1 exactly on the final byte of every `16*CHUNK_CLUSTERS` bytes emitted since reset, and only while `out_valid` is 1.
- R7: A cluster that completes while the output buffer is not free is discarded and sets `overflow`. `overflow` stays 1 until reset. The buffer counts as free if it is empty, or if its last byte is accepted in that same cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_byte` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One event tick present this cycle |
| smp_word | input | 16 | Samples of the tick, bit 4*k+c = channel c, sub-sample k |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_byte | output | 8 | Cluster stream byte |
| out_last | output | 1 | Last byte of a chunk |
| overflow | output | 1 | Sticky lost-cluster flag |

## Verification
The bench builds the block with an 8-bit timestamp, two clusters per chunk and a forcing interval of 16 ticks. With these values, several hundred ticks cover timestamp wraparound, many chunk boundaries and repeated forced clusters across long idle runs. An arithmetic model in the bench transposes each word, decides whether a cluster opens and queues the expected bytes. A second run holds the consumer stalled, which makes a completed cluster collide with an undrained one.

// File: rtl/evt_cluster_packer.sv
module evt_cluster_packer #(
  parameter int TS_W           = 16,
  parameter int CHUNK_CLUSTERS = 64,
  parameter int FORCE_TICKS    = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [15:0] smp_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte,
  output logic        out_last,
  output logic        overflow
);
  localparam int EVENTS      = 7;
  localparam int CL_BYTES    = 2 + 2 * EVENTS;
  localparam int CL_BITS     = 8 * CL_BYTES;
  localparam int CHUNK_BYTES = CHUNK_CLUSTERS * CL_BYTES;
  localparam int BIDX_W      = $clog2(CHUNK_BYTES);
  localparam int CNT_W       = $clog2(CL_BYTES + 1);
  localparam int GAP_W       = $clog2(FORCE_TICKS) + 1;
  localparam int FILL_W      = 3;

  logic [TS_W-1:0]           tick_q, ts_q;
  logic [3:0]                last_q;
  logic [FILL_W-1:0]         fill_q;
  logic [GAP_W-1:0]          gap_q;
  logic [16*(EVENTS-1)-1:0]  ev_q;
  logic [CL_BITS-1:0]        obuf_q;
  logic [CNT_W-1:0]          ocnt_q;
  logic [BIDX_W-1:0]         bidx_q;
  logic                      ovf_q;
  logic [15:0]               ev_word;

  always_comb
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 4; k++)
        ev_word[4*c+k] = smp_word[4*k+c];

  wire idle_tick = (smp_word == {4{last_q}});
  wire forced    = (gap_q >= GAP_W'(FORCE_TICKS));
  wire start     = smp_valid && (fill_q == '0) && (!idle_tick || forced);
  wire store     = smp_valid && ((fill_q != '0) || start);
  wire done      = store && (fill_q == FILL_W'(EVENTS - 1));
  wire take      = out_valid && out_ready;
  wire free      = (ocnt_q == '0) || ((ocnt_q == CNT_W'(1)) && out_ready);
  wire load      = done && free;
  wire [CL_BITS-1:0] cluster = {ev_word, ev_q, 16'(ts_q)};

  assign out_valid = (ocnt_q != '0);
  assign out_byte  = obuf_q[7:0];
  assign out_last  = out_valid && (bidx_q == BIDX_W'(CHUNK_BYTES - 1));
  assign overflow  = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      ts_q   <= '0;
      last_q <= '0;
      fill_q <= '0;
      gap_q  <= '0;
      ev_q   <= '0;
    end else if (smp_valid) begin
      tick_q <= tick_q + 1'b1;
      if (start) begin
        ts_q  <= tick_q;
        gap_q <= GAP_W'(1);
      end else if (!forced) begin
        gap_q <= gap_q + 1'b1;
      end
      if (store) begin
        last_q <= smp_word[15:12];
        if (done) fill_q <= '0;
        else begin
          fill_q <= fill_q + 1'b1;
          ev_q[16*fill_q +: 16] <= ev_word;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obuf_q <= '0;
      ocnt_q <= '0;
      bidx_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (load) begin
        obuf_q <= cluster;
        ocnt_q <= CNT_W'(CL_BYTES);
      end else if (take) begin
        obuf_q <= obuf_q >> 8;
        ocnt_q <= ocnt_q - 1'b1;
      end
      if (take)
        bidx_q <= (bidx_q == BIDX_W'(CHUNK_BYTES - 1)) ? '0 : bidx_q + 1'b1;
      if (done && !free) ovf_q <= 1'b1;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));
  p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_last_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  p_gap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_W'(FORCE_TICKS));
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q < FILL_W'(EVENTS));
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid && !overflow);
endmodule

// File: tb/evt_cluster_packer_test.sv
module evt_cluster_packer_test;
  localparam int TS_W = 8, CHUNK_CL = 2, FORCE = 16;
  localparam int CHUNK_B = 16 * CHUNK_CL;

  logic clk = 0, rst_n = 0, smp_valid = 0, out_ready = 0;
  logic [15:0] smp_word = '0;
  logic out_valid, out_last, overflow;
  logic [7:0] out_byte;

  evt_cluster_packer #(.TS_W(TS_W), .CHUNK_CLUSTERS(CHUNK_CL), .FORCE_TICKS(FORCE)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last), .overflow(overflow));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, chunk_ends = 0, rx_count = 0, cyc = 0;
  bit ready_low = 1, cmp_en = 1, done_flag = 0;
  logic [7:0] exp_q[$];
  logic [7:0] held_b;
  bit held = 0;

  int m_tick, m_gap, m_fill, m_ts;
  logic [3:0] m_last;
  logic [15:0] m_ev[7];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_tick = 0; m_gap = 0; m_fill = 0; m_ts = 0; m_last = 0;
    exp_q.delete();
  endtask

  function automatic logic [15:0] xpose(input logic [15:0] w);
    logic [15:0] r;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 4; k++) r[4*c+k] = w[4*k+c];
    return r;
  endfunction

  task automatic model_step(input logic [15:0] w);
    bit st;
    st = (m_fill == 0) && ((w != {4{m_last}}) || (m_gap >= FORCE));
    if (st) begin m_ts = m_tick; m_gap = 1; end
    else if (m_gap < FORCE) m_gap++;
    if (m_fill != 0 || st) begin
      m_ev[m_fill] = xpose(w);
      m_last = w[15:12];
      m_fill++;
      if (m_fill == 7) begin
        m_fill = 0;
        exp_q.push_back(8'(m_ts));
        exp_q.push_back(8'(m_ts >> 8));
        for (int i = 0; i < 7; i++) begin
          exp_q.push_back(m_ev[i][7:0]);
          exp_q.push_back(m_ev[i][15:8]);
        end
      end
    end
    m_tick = (m_tick + 1) % (1 << TS_W);
  endtask

  task automatic tick(input logic [15:0] w);
    @(posedge clk); #1;
    smp_valid = 1; smp_word = w;
    model_step(w);
    @(posedge clk); #1;
    smp_valid = 0;
    repeat (2) @(posedge clk);
  endtask

  function automatic logic [15:0] next_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    out_ready = ready_low ? 1'b0 : (cyc % 4 != 3);
  end

  always @(negedge clk) begin
    if (rst_n && held) begin
      check(out_valid && out_byte == held_b, "R8 hold", {out_valid, out_byte}, {1'b1, held_b});
    end
    held = rst_n && out_valid && !out_ready;
    held_b = out_byte;
    if (rst_n && out_valid && out_ready) begin
      rx_count++;
      if (cmp_en) begin
        logic [7:0] e;
        int pos;
        pos = (rx_count - 1) % 16;
        if (exp_q.size() == 0) check(0, "R4 unexpected byte", out_byte, 0);
        else begin
          e = exp_q.pop_front();
          check(out_byte == e, pos < 2 ? "R3 timestamp byte" : "R2 event byte", out_byte, e);
        end
        check(out_last == ((rx_count % CHUNK_B) == 0), "R6 chunk marker", out_last,
              (rx_count % CHUNK_B) == 0);
        if (out_last) chunk_ends++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !overflow, "R1 reset state", {out_valid, overflow}, 0);
    @(posedge clk); #1; rst_n = 1; ready_low = 0;

    // R9-like reset sample: zero words are idle (R1, R4)
    for (int i = 0; i < 5; i++) tick(16'h0000);
    @(negedge clk);
    check(!out_valid && exp_q.size() == 0, "R4 idle ticks stored nothing", out_valid, 0);
    // R5: continue idle until forced cluster at tick 16
    for (int i = 0; i < 20; i++) tick(16'h0000);
    // active words
    for (int i = 0; i < 30; i++) begin lfsr = next_lfsr(lfsr); tick(lfsr); end
    // idle runs of the last stored sample: only forced clusters (R5)
    for (int i = 0; i < 50; i++) tick({4{m_last}});
    // directed transposition words (R2)
    tick(16'h000F); tick(16'hF000); tick(16'h1248); tick(16'h8421);
    tick(16'h0F0F); tick(16'h3333); tick(16'hFFFF);
    // mixed, crosses the timestamp wrap (R3)
    for (int i = 0; i < 320; i++) begin
      lfsr = next_lfsr(lfsr);
      if ((i / 20) % 2 == 1) tick({4{m_last}});
      else tick(lfsr);
    end
    repeat (100) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R4 all clusters emitted", exp_q.size(), 0);
    check(!overflow, "R7 no overflow at sustainable rate", overflow, 0);
    check(chunk_ends >= 4, "R6 chunk ends seen", chunk_ends, 4);

    // overflow scenario (R7)
    @(posedge clk); #1; rst_n = 0; ready_low = 1; cmp_en = 0;
    model_reset();
    repeat (2) @(posedge clk); #1; rst_n = 1;
    for (int i = 0; i < 7; i++) tick(i[0] ? 16'h1234 : 16'h4321);
    @(negedge clk);
    check(out_valid && out_byte == 8'h00 && !overflow, "R7 first cluster held",
          {out_valid, overflow, out_byte}, 10'h200);
    for (int i = 0; i < 7; i++) tick(i[0] ? 16'h1234 : 16'h4321);
    @(negedge clk);
    check(overflow, "R7 overflow raised", overflow, 1);
    rx_count = 0;
    @(posedge clk); #1; ready_low = 0;
    repeat (60) @(posedge clk);
    @(negedge clk);
    check(rx_count == 16, "R7 second cluster dropped", rx_count, 16);
    check(overflow && !out_valid, "R7 overflow sticky", {overflow, out_valid}, 2'b10);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule